// File: doc/BRIEF.md
# Fully Associative TLB with Lockdown

This block is a small translation cache that sits between an address-generating unit and a hardware page-table walker. It holds recently used virtual-to-physical translations, each with its access-permission bits and a set of memory attributes. A lookup presents a virtual address. The block first folds the current process identifier into the address when the top of the address is empty. It then compares the result against every stored translation at once and answers in the same cycle with either a hit or a miss.

On a hit the block returns the physical address, the permission bits and the attribute bits. A hit can come from a 1 MB section or from a 4 KB small page. On a miss the block raises a walk request toward an external walker and stalls further lookups until the walker answers with a fill. The fill is written over a victim chosen by a rotating pointer.

Any fill may mark its entry as locked. Locked entries are never picked as victims and survive a bulk flush. A flush of a single page removes its entry whether it is locked or not.

Top module: `fa_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `busy_o` and `walk_req_o` are low.
- R2: When virtual address bits [31:25] are all zero, they are replaced by the 7-bit `pid_i` before matching and before being sent on `walk_va_o`. Any other address is used unchanged.
- R3: A lookup that matches a valid entry raises `lk_hit_o` in the same cycle, with that entry's permission bits on `lk_rights_o` and its attribute bits on `lk_attr_o`. `lk_hit_o` and `lk_miss_o` are never high together, and both are low when `lk_valid_i` is low.
- R4: A section entry (`fill_section_i`=1) matches on virtual bits [31:20] and returns `{frame[19:8], va[19:0]}`. A small-page entry matches on bits [31:12] and returns `{frame[19:0], va[11:0]}`.
- R5: A lookup that misses while idle raises `lk_miss_o` in that cycle. From the next cycle `walk_req_o` is high, and `walk_va_o` holds the (remapped) lookup address, both stable until a fill arrives.
- R6: While a walk is outstanding `busy_o` is high, and lookups give neither a hit nor a miss.
- R7: A cycle with `fill_valid_i` high during an outstanding walk completes the walk. From the next cycle `busy_o` is low, and a lookup of the walked address hits with the filled frame, rights and attributes.
- R8: Victims are chosen by a pointer that starts at entry 0. A fill goes to the first unlocked entry at or after the pointer, wrapping around, and the pointer then moves to the entry after the victim. Once every entry has been used, the next fill therefore evicts the least recently filled unlocked entry.
- R9: An entry filled with `fill_lock_i`=1 is never chosen as a victim and stays resident across any number of later fills.
- R10: If every entry is locked, a fill is discarded, `fill_drop_o` is high in the fill cycle, and the walk still completes, so a repeat lookup misses again.
- R11: A one-cycle `inv_all_i` clears every unlocked entry and leaves locked entries valid.
- R12: A one-cycle `inv_one_i` clears the entry matching the (remapped) page number `inv_vpn_i` even if it is locked, and that entry becomes free for replacement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pid_i | input | 7 | Process identifier used for address folding |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit (combinational) |
| lk_miss_o | output | 1 | Lookup miss (combinational) |
| lk_pa_o | output | 32 | Translated physical address |
| lk_rights_o | output | 2 | Permission bits of the hit entry |
| lk_attr_o | output | 7 | Attribute bits of the hit entry |
| busy_o | output | 1 | Walk outstanding, lookups stalled |
| walk_req_o | output | 1 | Walk request to the external walker |
| walk_va_o | output | 32 | Remapped address to walk |
| fill_valid_i | input | 1 | Walker response valid |
| fill_frame_i | input | 20 | Physical frame number of the response |
| fill_section_i | input | 1 | Response is a 1 MB section (else 4 KB page) |
| fill_rights_i | input | 2 | Permission bits of the response |
| fill_attr_i | input | 7 | Attribute bits of the response |
| fill_lock_i | input | 1 | Lock the new entry |
| fill_drop_o | output | 1 | Fill discarded because all entries are locked |
| inv_all_i | input | 1 | Invalidate all unlocked entries |
| inv_one_i | input | 1 | Invalidate the entry matching inv_vpn_i |
| inv_vpn_i | input | 20 | Virtual page number to invalidate |

## Verification
The properties assume that the walker drives `fill_valid_i` only while `walk_req_o` is high, and that each fill lasts a single cycle. They also assume that the lookup address has no unknown bits whenever `lk_valid_i` is high. The stimulus meets these assumptions by design. It answers a walk only after it has seen `walk_req_o` at a falling edge, it holds `fill_valid_i` for exactly one cycle, and it raises at most one flush command at a time, never in the same cycle as a fill.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;

   // Memory attributes carried with every translation.
   typedef struct packed {
      logic coalesce;
      logic mini_cache;
      logic io_space;
      logic write_back;
      logic read_alloc;
      logic bufferable;
      logic cacheable;
   } tlb_attr_t;

   localparam int ATTR_BITS = $bits(tlb_attr_t);

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_WAIT = 1'b1
   } walk_state_e;

endpackage

// File: rtl/fa_tlb_remap.sv
module fa_tlb_remap #(
   parameter int VPN_W    = 20,
   parameter int PID_W    = 7,
   parameter bit REMAP_EN = 1'b1
) (
   input  logic [PID_W-1:0] pid_i,
   input  logic [VPN_W-1:0] vpn_i,
   output logic [VPN_W-1:0] vpn_o
);

   generate
      if (REMAP_EN) begin : g_fold
         logic top_empty;
         assign top_empty = (vpn_i[VPN_W-1 -: PID_W] == '0);
         always_comb begin
            if (top_empty) vpn_o = {pid_i, vpn_i[VPN_W-PID_W-1:0]};
            else           vpn_o = vpn_i;
         end
      end else begin : g_pass
         logic [PID_W-1:0] pid_unused;
         assign pid_unused = pid_i;
         assign vpn_o      = vpn_i;
      end
   endgenerate

endmodule

// File: rtl/fa_tlb_match.sv
module fa_tlb_match #(
   parameter int ENTRIES   = 32,
   parameter int VPN_W     = 20,
   parameter int SEC_CMP_W = 12
) (
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] section_i,
   input  logic [VPN_W-1:0]   tag_i [ENTRIES],
   input  logic [VPN_W-1:0]   key_i,
   output logic [ENTRIES-1:0] match_o
);

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         logic sec_eq;
         logic page_eq;
         assign sec_eq  = (tag_i[g][VPN_W-1 -: SEC_CMP_W] == key_i[VPN_W-1 -: SEC_CMP_W]);
         assign page_eq = (tag_i[g] == key_i);
         assign match_o[g] = valid_i[g] & (section_i[g] ? sec_eq : page_eq);
      end
   endgenerate

endmodule

// File: rtl/fa_tlb_prio.sv
module fa_tlb_prio #(
   parameter int ENTRIES = 32,
   parameter int IDX_W   = 5
) (
   input  logic [ENTRIES-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/fa_tlb_victim.sv
module fa_tlb_victim #(
   parameter int ENTRIES = 32,
   parameter int IDX_W   = 5
) (
   input  logic [ENTRIES-1:0] locked_i,
   input  logic [IDX_W-1:0]   ptr_i,
   output logic               found_o,
   output logic [IDX_W-1:0]   idx_o
);

   // Scan from the pointer upward, wrapping; ENTRIES is a power of two
   // so the IDX_W-bit sum wraps on its own.
   always_comb begin
      logic [IDX_W-1:0] cand;
      found_o = 1'b0;
      idx_o   = ptr_i;
      cand    = ptr_i;
      for (int k = 0; k < ENTRIES; k++) begin
         cand = ptr_i + IDX_W'(k);
         if (!found_o && !locked_i[cand]) begin
            found_o = 1'b1;
            idx_o   = cand;
         end
      end
   end

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
   import fa_tlb_pkg::*;
#(
   parameter int ENTRIES  = 32,
   parameter int ADDR_W   = 32,
   parameter int PID_W    = 7,
   parameter int PG_OFF_W = 12,
   parameter int SEC_OFF_W = 20,
   parameter int RIGHTS_W = 2,
   parameter bit REMAP_EN = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [PID_W-1:0]      pid_i,
   input  logic                  lk_valid_i,
   input  logic [ADDR_W-1:0]     lk_va_i,
   output logic                  lk_hit_o,
   output logic                  lk_miss_o,
   output logic [ADDR_W-1:0]     lk_pa_o,
   output logic [RIGHTS_W-1:0]   lk_rights_o,
   output logic [ATTR_BITS-1:0]  lk_attr_o,
   output logic                  busy_o,
   output logic                  walk_req_o,
   output logic [ADDR_W-1:0]     walk_va_o,
   input  logic                  fill_valid_i,
   input  logic [ADDR_W-PG_OFF_W-1:0] fill_frame_i,
   input  logic                  fill_section_i,
   input  logic [RIGHTS_W-1:0]   fill_rights_i,
   input  logic [ATTR_BITS-1:0]  fill_attr_i,
   input  logic                  fill_lock_i,
   output logic                  fill_drop_o,
   input  logic                  inv_all_i,
   input  logic                  inv_one_i,
   input  logic [ADDR_W-PG_OFF_W-1:0] inv_vpn_i
);

   localparam int IDX_W     = $clog2(ENTRIES);
   localparam int VPN_W     = ADDR_W - PG_OFF_W;
   localparam int SEC_CMP_W = ADDR_W - SEC_OFF_W;

   // ---------------- elaboration checks ----------------
   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("fa_tlb: ENTRIES must be a power of two of at least 2");
      end
      if (SEC_OFF_W <= PG_OFF_W || SEC_OFF_W >= ADDR_W) begin : g_bad_sizes
         $error("fa_tlb: section offset must exceed page offset and fit the address");
      end
      if (PID_W < 1 || PID_W > SEC_CMP_W) begin : g_bad_pid
         $error("fa_tlb: process-ID field must lie inside the section tag");
      end
   endgenerate

   // ---------------- storage ----------------
   logic [ENTRIES-1:0]  ent_valid_q;
   logic [ENTRIES-1:0]  ent_lock_q;
   logic [ENTRIES-1:0]  ent_sec_q;
   logic [VPN_W-1:0]    ent_tag_q    [ENTRIES];
   logic [VPN_W-1:0]    ent_frame_q  [ENTRIES];
   logic [RIGHTS_W-1:0] ent_rights_q [ENTRIES];
   tlb_attr_t           ent_attr_q   [ENTRIES];

   walk_state_e         state_q;
   logic [ADDR_W-1:0]   walk_va_q;
   logic [IDX_W-1:0]    rr_q;

   // ---------------- lookup path ----------------
   logic [VPN_W-1:0]    lk_vpn;
   logic [ENTRIES-1:0]  lk_match;
   logic                lk_any;
   logic [IDX_W-1:0]    lk_idx;
   logic                lk_go;

   fa_tlb_remap #(.VPN_W(VPN_W), .PID_W(PID_W), .REMAP_EN(REMAP_EN)) u_lk_remap (
      .pid_i (pid_i),
      .vpn_i (lk_va_i[ADDR_W-1:PG_OFF_W]),
      .vpn_o (lk_vpn)
   );

   fa_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .SEC_CMP_W(SEC_CMP_W)) u_lk_match (
      .valid_i   (ent_valid_q),
      .section_i (ent_sec_q),
      .tag_i     (ent_tag_q),
      .key_i     (lk_vpn),
      .match_o   (lk_match)
   );

   fa_tlb_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_prio (
      .req_i (lk_match),
      .any_o (lk_any),
      .idx_o (lk_idx)
   );

   assign lk_go     = lk_valid_i && (state_q == WALK_IDLE);
   assign lk_hit_o  = lk_go && lk_any;
   assign lk_miss_o = lk_go && !lk_any;

   always_comb begin
      lk_pa_o     = '0;
      lk_rights_o = '0;
      lk_attr_o   = '0;
      if (lk_hit_o) begin
         if (ent_sec_q[lk_idx]) begin
            lk_pa_o = {ent_frame_q[lk_idx][VPN_W-1 -: SEC_CMP_W], lk_va_i[SEC_OFF_W-1:0]};
         end else begin
            lk_pa_o = {ent_frame_q[lk_idx], lk_va_i[PG_OFF_W-1:0]};
         end
         lk_rights_o = ent_rights_q[lk_idx];
         lk_attr_o   = ent_attr_q[lk_idx];
      end
   end

   // ---------------- walk handshake ----------------
   logic fill_fire;
   logic vic_found;
   logic [IDX_W-1:0] vic_idx;
   logic fill_wr;

   assign busy_o      = (state_q == WALK_WAIT);
   assign walk_req_o  = (state_q == WALK_WAIT);
   assign walk_va_o   = walk_va_q;
   assign fill_fire   = (state_q == WALK_WAIT) && fill_valid_i;

   fa_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .locked_i (ent_lock_q),
      .ptr_i    (rr_q),
      .found_o  (vic_found),
      .idx_o    (vic_idx)
   );

   assign fill_wr     = fill_fire && vic_found;
   assign fill_drop_o = fill_fire && !vic_found;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q   <= WALK_IDLE;
         walk_va_q <= '0;
         rr_q      <= '0;
      end else begin
         case (state_q)
            WALK_IDLE: begin
               if (lk_miss_o) begin
                  state_q   <= WALK_WAIT;
                  walk_va_q <= {lk_vpn, lk_va_i[PG_OFF_W-1:0]};
               end
            end
            WALK_WAIT: begin
               if (fill_valid_i) state_q <= WALK_IDLE;
            end
            default: state_q <= WALK_IDLE;
         endcase
         if (fill_wr) rr_q <= vic_idx + 1'b1;
      end
   end

   // ---------------- invalidate path ----------------
   logic [VPN_W-1:0]   inv_vpn;
   logic [ENTRIES-1:0] inv_match;

   fa_tlb_remap #(.VPN_W(VPN_W), .PID_W(PID_W), .REMAP_EN(REMAP_EN)) u_inv_remap (
      .pid_i (pid_i),
      .vpn_i (inv_vpn_i),
      .vpn_o (inv_vpn)
   );

   fa_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .SEC_CMP_W(SEC_CMP_W)) u_inv_match (
      .valid_i   (ent_valid_q),
      .section_i (ent_sec_q),
      .tag_i     (ent_tag_q),
      .key_i     (inv_vpn),
      .match_o   (inv_match)
   );

   // ---------------- entry state update ----------------
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ent_valid_q <= '0;
         ent_lock_q  <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (inv_all_i && !ent_lock_q[i]) ent_valid_q[i] <= 1'b0;
            if (inv_one_i && inv_match[i]) begin
               ent_valid_q[i] <= 1'b0;
               ent_lock_q[i]  <= 1'b0;
            end
            if (fill_wr && (vic_idx == IDX_W'(i))) begin
               ent_valid_q[i] <= 1'b1;
               ent_lock_q[i]  <= fill_lock_i;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (fill_wr) begin
         ent_sec_q[vic_idx]    <= fill_section_i;
         ent_tag_q[vic_idx]    <= walk_va_q[ADDR_W-1:PG_OFF_W];
         ent_frame_q[vic_idx]  <= fill_frame_i;
         ent_rights_q[vic_idx] <= fill_rights_i;
         ent_attr_q[vic_idx]   <= tlb_attr_t'(fill_attr_i);
      end
   end

endmodule

// File: rtl/fa_tlb_chk.sv
module fa_tlb_chk #(
   parameter int ADDR_W   = 32,
   parameter int PG_OFF_W = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              lk_valid_i,
   input logic [ADDR_W-1:0] lk_va_i,
   input logic              lk_hit_o,
   input logic              lk_miss_o,
   input logic [ADDR_W-1:0] lk_pa_o,
   input logic              busy_o,
   input logic              walk_req_o,
   input logic [ADDR_W-1:0] walk_va_o,
   input logic              fill_valid_i,
   input logic              fill_drop_o
);

   AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lk_hit_o && lk_miss_o)); // R3

   AST_RESULT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_hit_o || lk_miss_o) |-> lk_valid_i); // R3

   AST_PAGE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hit_o |-> (lk_pa_o[PG_OFF_W-1:0] == lk_va_i[PG_OFF_W-1:0])); // R4

   AST_MISS_WALKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_miss_o |=> (walk_req_o && busy_o)); // R5

   AST_WALK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (walk_req_o && !fill_valid_i) |=> (walk_req_o && $stable(walk_va_o))); // R5

   AST_BUSY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (!lk_hit_o && !lk_miss_o)); // R6

   AST_FILL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (walk_req_o && fill_valid_i) |=> !busy_o); // R7

   AST_NO_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_drop_o |-> (walk_req_o && fill_valid_i)); // R10

endmodule

bind fa_tlb fa_tlb_chk #(.ADDR_W(ADDR_W), .PG_OFF_W(PG_OFF_W)) u_fa_tlb_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .lk_valid_i   (lk_valid_i),
   .lk_va_i      (lk_va_i),
   .lk_hit_o     (lk_hit_o),
   .lk_miss_o    (lk_miss_o),
   .lk_pa_o      (lk_pa_o),
   .busy_o       (busy_o),
   .walk_req_o   (walk_req_o),
   .walk_va_o    (walk_va_o),
   .fill_valid_i (fill_valid_i),
   .fill_drop_o  (fill_drop_o)
);

// File: tb/fa_tlb_bench.sv
module fa_tlb_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  pid;
   logic        lk_valid;
   logic [31:0] lk_va;
   logic        lk_hit, lk_miss;
   logic [31:0] lk_pa;
   logic [1:0]  lk_rights;
   logic [6:0]  lk_attr;
   logic        busy, walk_req;
   logic [31:0] walk_va;
   logic        fill_valid;
   logic [19:0] fill_frame;
   logic        fill_sec;
   logic [1:0]  fill_rights;
   logic [6:0]  fill_attr;
   logic        fill_lock;
   logic        fill_drop;
   logic        inv_all, inv_one;
   logic [19:0] inv_vpn;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   fa_tlb u_fa_tlb (
      .clk_i(clk), .rst_ni(rst_n), .pid_i(pid),
      .lk_valid_i(lk_valid), .lk_va_i(lk_va),
      .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_pa_o(lk_pa),
      .lk_rights_o(lk_rights), .lk_attr_o(lk_attr),
      .busy_o(busy), .walk_req_o(walk_req), .walk_va_o(walk_va),
      .fill_valid_i(fill_valid), .fill_frame_i(fill_frame), .fill_section_i(fill_sec),
      .fill_rights_i(fill_rights), .fill_attr_i(fill_attr), .fill_lock_i(fill_lock),
      .fill_drop_o(fill_drop),
      .inv_all_i(inv_all), .inv_one_i(inv_one), .inv_vpn_i(inv_vpn)
   );

   typedef struct packed {
      logic [6:0]  pid;
      logic [31:0] va;
      logic        hit;
      logic [31:0] pa;
   } vec_t;

   // Lookups after a section at remapped 0x0A1xxxxx -> 0x800xxxxx is installed.
   // Misses are answered with a small-page fill of frame 0xDEAD0.
   localparam vec_t VECS [8] = '{
      '{7'h05, 32'h0012_3456, 1'b1, 32'h8002_3456},
      '{7'h06, 32'h0012_3456, 1'b0, 32'h0},
      '{7'h06, 32'h0012_3456, 1'b1, 32'hDEAD_0456},
      '{7'h05, 32'h0A1F_FFFF, 1'b1, 32'h800F_FFFF},
      '{7'h05, 32'h0020_0000, 1'b0, 32'h0},
      '{7'h05, 32'h0020_0ABC, 1'b1, 32'hDEAD_0ABC},
      '{7'h05, 32'h0020_1ABC, 1'b0, 32'h0},
      '{7'h05, 32'h0020_1ABC, 1'b1, 32'hDEAD_0ABC}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] va, output logic h, output logic m,
                         output logic [31:0] pa);
      lk_valid = 1'b1;
      lk_va    = va;
      #1;
      h  = lk_hit;
      m  = lk_miss;
      pa = lk_pa;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [19:0] frame, input logic sec, input logic lock,
                       input logic [1:0] rights, output logic drop);
      fill_valid  = 1'b1;
      fill_frame  = frame;
      fill_sec    = sec;
      fill_lock   = lock;
      fill_rights = rights;
      fill_attr   = 7'h15;
      #1;
      drop = fill_drop;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic install(input logic [31:0] va, input logic [19:0] frame, input logic sec,
                          input logic lock, output logic drop);
      logic h, m;
      logic [31:0] pa;
      lookup(va, h, m, pa);
      check("R5 install lookup misses", {63'b0, m}, 64'd1);
      fill(frame, sec, lock, 2'd1, drop);
   endtask

   task automatic pulse_inv(input logic all, input logic [19:0] vpn);
      inv_all = all;
      inv_one = !all;
      inv_vpn = vpn;
      @(negedge clk);
      inv_all = 1'b0;
      inv_one = 1'b0;
   endtask

   initial begin
      logic h, m, d;
      logic [31:0] pa;
      rst_n = 1'b0; pid = '0; lk_valid = 1'b0; lk_va = '0;
      fill_valid = 1'b0; fill_frame = '0; fill_sec = 1'b0; fill_rights = '0;
      fill_attr = '0; fill_lock = 1'b0; inv_all = 1'b0; inv_one = 1'b0; inv_vpn = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy after reset", {63'b0, busy}, 64'd0);
      check("R1 walk_req after reset", {63'b0, walk_req}, 64'd0);
      lookup(32'h1234_5678, h, m, pa);
      check("R1 first lookup misses", {62'b0, h, m}, 64'd1);
      check("R5 walk_req after miss", {63'b0, walk_req}, 64'd1);
      check("R5 walk address unchanged (top bits set)", {32'b0, walk_va}, 64'h1234_5678);
      // R6 stalled lookup
      lookup(32'h1234_5678, h, m, pa);
      check("R6 no hit or miss while busy", {62'b0, h, m}, 64'd0);
      check("R6 busy held", {63'b0, busy}, 64'd1);
      fill(20'hABCDE, 1'b0, 1'b0, 2'd2, d);
      check("R7 busy clears after fill", {63'b0, busy}, 64'd0);
      lk_valid = 1'b1; lk_va = 32'h1234_5678;
      #1;
      check("R3 hit same cycle", {62'b0, lk_hit, lk_miss}, 64'd2);
      check("R7 filled frame", {32'b0, lk_pa}, 64'hABCD_E678);
      check("R3 rights", {62'b0, lk_rights}, 64'd2);
      check("R3 attributes", {57'b0, lk_attr}, 64'h15);
      @(negedge clk);
      lk_valid = 1'b0;

      // R2 section install under pid 5
      pid = 7'h05;
      lookup(32'h0010_0000, h, m, pa);
      check("R2 remapped walk address", {32'b0, walk_va}, 64'h0A10_0000);
      fill(20'h80000, 1'b1, 1'b0, 2'd3, d);

      // table walk: R2 / R4 / R7
      for (int i = 0; i < 8; i++) begin
         pid = VECS[i].pid;
         lookup(VECS[i].va, h, m, pa);
         check($sformatf("R2/R4 vector %0d hit", i), {63'b0, h}, {63'b0, VECS[i].hit});
         if (VECS[i].hit) check($sformatf("R4/R7 vector %0d pa", i), {32'b0, pa}, {32'b0, VECS[i].pa});
         else fill(20'hDEAD0, 1'b0, 1'b0, 2'd1, d);
      end
      pid = '0;

      // entries 0..4 used, pointer at 5
      install(32'h4000_0ABC, 20'h11111, 1'b0, 1'b1, d);   // locked, entry 5
      pulse_inv(1'b1, '0);
      lookup(32'h1234_5678, h, m, pa);
      check("R11 unlocked entry flushed", {63'b0, m}, 64'd1);
      fill(20'hABCDE, 1'b0, 1'b0, 2'd2, d);               // entry 6
      lookup(32'h4000_0ABC, h, m, pa);
      check("R11 locked entry survives flush", {32'b0, pa}, 64'h1111_1ABC);

      // R8 / R9 round robin with one locked entry
      for (int k = 0; k < 32; k++) begin
         install(32'h5000_0000 + (k << 12), 20'h20000 + 20'(k), 1'b0, 1'b0, d);
         check("R8 fill accepted", {63'b0, d}, 64'd0);
      end
      lookup(32'h5000_1000, h, m, pa);
      check("R8 second-oldest still resident", {32'b0, pa}, 64'h2000_1000);
      lookup(32'h4000_0ABC, h, m, pa);
      check("R9 locked entry never evicted", {32'b0, pa}, 64'h1111_1ABC);
      lookup(32'h5000_0000, h, m, pa);
      check("R8 oldest entry evicted", {63'b0, m}, 64'd1);
      fill(20'h20000, 1'b0, 1'b0, 2'd1, d);

      // R12 single invalidate of a locked entry
      pulse_inv(1'b0, 20'h40000);
      lookup(32'h4000_0ABC, h, m, pa);
      check("R12 locked entry cleared by single invalidate", {63'b0, m}, 64'd1);
      fill(20'h11111, 1'b0, 1'b0, 2'd1, d);

      // R10 every entry locked
      pulse_inv(1'b1, '0);
      for (int k = 0; k < 32; k++) begin
         install(32'h6000_0000 + (k << 12), 20'h30000 + 20'(k), 1'b0, 1'b1, d);
         check("R10 no drop while a slot is free", {63'b0, d}, 64'd0);
      end
      lookup(32'h7000_0000, h, m, pa);
      fill(20'h44444, 1'b0, 1'b0, 2'd1, d);
      check("R10 fill dropped when all locked", {63'b0, d}, 64'd1);
      check("R10 walk completes", {63'b0, busy}, 64'd0);
      lookup(32'h7000_0000, h, m, pa);
      check("R10 dropped translation absent", {63'b0, m}, 64'd1);
      fill(20'h44444, 1'b0, 1'b0, 2'd1, d);
      check("R10 second drop", {63'b0, d}, 64'd1);
      pulse_inv(1'b1, '0);
      lookup(32'h6000_3000, h, m, pa);
      check("R11 locked entries kept", {32'b0, pa}, 64'h3000_3000);
      pulse_inv(1'b0, 20'h60003);
      lookup(32'h6000_3000, h, m, pa);
      check("R12 single invalidate of locked page", {63'b0, m}, 64'd1);
      fill(20'h55555, 1'b0, 1'b0, 2'd1, d);
      check("R12 freed slot reusable", {63'b0, d}, 64'd0);
      lookup(32'h6000_3000, h, m, pa);
      check("R12 refill hits", {32'b0, pa}, 64'h5555_5000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule